// File: doc/BRIEF.md
# Hall-Sensed Six-Step Bridge Commutator

This block commutates a three-phase brushless DC motor. Three hall sensor lines are brought into the clock domain, filtered against short glitches and decoded into one of six 60-degree electrical steps. For each step, a fixed table gives every half bridge one of three conditions: floating (both switches open), grounded (low switch closed), or modulated (the two switches alternate as a complementary pair at the PWM rate).

A free-running PWM counter compares against a duty input to set the average voltage on the modulated phase. Each phase has its own gate stage. Whenever the gate pair requested for a phase changes, that stage opens both switches for a fixed number of clock cycles before it closes either one. The two hall codes that cannot occur on a healthy motor force every switch open and raise a fault output. The fault clears as soon as a legal code is decoded again.

Top module: `sixstep_commutator`

## Requirements
- R1: While `rst_n` is low, and until the first filtered hall code is available, all six gate outputs and `fault` are 0.
- R2: The filtered code {hall_in[2], hall_in[1], hall_in[0]} selects the conditions of phases A, B and C (P = modulated, L = grounded, Z = floating): 000 gives Z L P, 100 gives P L Z, 110 gives P Z L, 111 gives Z P L, 011 gives L P Z, and 001 gives L Z P.
- R3: A floating phase holds both its gate outputs at 0.
- R4: A grounded phase holds its low gate at 1 and its high gate at 0.
- R5: In a modulated phase, the high-side request is on while the PWM counter (0 to PWM_PERIOD-1) is below the duty latched at the start of the period, and the low-side request is on for the rest of the period. With 0 < duty < PWM_PERIOD, each period has max(0, duty-DEAD_CYC) high-gate cycles and max(0, PWM_PERIOD-duty-DEAD_CYC) low-gate cycles.
- R6: With duty 0, a modulated phase holds its low gate at 1 continuously. With duty >= PWM_PERIOD, it holds its high gate at 1 continuously.
- R7: After the gate request of a phase changes, both gates of that phase stay 0 for DEAD_CYC cycles. A gate only rises after at least DEAD_CYC cycles in which both gates of its phase were 0.
- R8: Hall codes 010 and 101 force all six gates to 0 and set `fault`. `fault` returns to 0 once a legal code is decoded.
- R9: After two synchronising flops, a hall code must be stable for DEB_CYC cycles before it is decoded. A change that lasts fewer cycles has no effect on the gates or on `fault`.
- R10: The two gates of one phase are never 1 together, and at most one high gate is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hall_in | input | 3 | Raw hall lines: bit 2 = HC, bit 1 = HB, bit 0 = HA |
| duty | input | $clog2(PWM_PERIOD+1) | High-side on-count per PWM period |
| gate_hi | output | 3 | High-side gate enables: bit 0 = A, bit 1 = B, bit 2 = C |
| gate_lo | output | 3 | Low-side gate enables, same bit order |
| fault | output | 1 | Illegal hall code decoded |

## Verification
The assertions take for granted that DEAD_CYC is at least one and that a modulated phase is only ever paired with one grounded phase, so a single high-side gate can be on at a time. The bench changes the hall code and the duty only on falling clock edges, and it holds each setting for more than two PWM periods before it measures anything. As a result, a latched duty and a debounced code are always settled inside the measured window. The one deliberately short change, a two-cycle illegal code, is kept below the debounce length, so the filter is expected to reject it.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;

    typedef enum logic [1:0] {
        BR_OFF = 2'd0,
        BR_LOW = 2'd1,
        BR_PWM = 2'd2
    } br_mode_e;

    typedef struct packed {
        br_mode_e a;
        br_mode_e b;
        br_mode_e c;
        logic     bad;
    } step_cmd_t;

    // code bits are {HC, HB, HA}; result modes are for phases A, B, C
    function automatic step_cmd_t decode_hall(input logic [2:0] code);
        step_cmd_t r;
        r = '{a: BR_OFF, b: BR_OFF, c: BR_OFF, bad: 1'b0};
        case (code)
            3'b000:  begin r.a = BR_OFF; r.b = BR_LOW; r.c = BR_PWM; end
            3'b100:  begin r.a = BR_PWM; r.b = BR_LOW; r.c = BR_OFF; end
            3'b110:  begin r.a = BR_PWM; r.b = BR_OFF; r.c = BR_LOW; end
            3'b111:  begin r.a = BR_OFF; r.b = BR_PWM; r.c = BR_LOW; end
            3'b011:  begin r.a = BR_LOW; r.b = BR_PWM; r.c = BR_OFF; end
            3'b001:  begin r.a = BR_LOW; r.b = BR_OFF; r.c = BR_PWM; end
            default: r.bad = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sixstep_hall_filter.sv
module sixstep_hall_filter #(
    parameter int DEB_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_raw,
    output logic [2:0] hall_clean,
    output logic       hall_valid
);
    localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC + 1) : 1;

    typedef struct packed {
        logic [2:0]    s1;
        logic [2:0]    s2;
        logic [2:0]    cand;
        logic [2:0]    clean;
        logic [CW-1:0] cnt;
        logic          valid;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d    = flt_q;
        flt_d.s1 = hall_raw;
        flt_d.s2 = flt_q.s1;
        if (flt_q.s2 != flt_q.cand) begin
            flt_d.cand = flt_q.s2;
            flt_d.cnt  = '0;
        end else if (flt_q.cnt != CW'(DEB_CYC - 1)) begin
            flt_d.cnt = flt_q.cnt + CW'(1);
        end else begin
            flt_d.clean = flt_q.cand;
            flt_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign hall_clean = flt_q.clean;
    assign hall_valid = flt_q.valid;
endmodule

// File: rtl/sixstep_pwm_gen.sv
module sixstep_pwm_gen #(
    parameter int PWM_PERIOD = 1000
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [$clog2(PWM_PERIOD+1)-1:0]   duty,
    output logic                              pwm
);
    localparam int DW    = $clog2(PWM_PERIOD + 1);
    localparam int CNT_W = (PWM_PERIOD > 1) ? $clog2(PWM_PERIOD) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [DW-1:0]    duty;
    } pwm_t;

    pwm_t pwm_d, pwm_q;

    always_comb begin
        pwm_d = pwm_q;
        if (pwm_q.cnt == CNT_W'(PWM_PERIOD - 1)) begin
            pwm_d.cnt  = '0;
            pwm_d.duty = duty;   // new duty only takes effect at a period boundary
        end else begin
            pwm_d.cnt = pwm_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= '0;
        else        pwm_q <= pwm_d;
    end

    assign pwm = (DW'(pwm_q.cnt) < pwm_q.duty);
endmodule

// File: rtl/sixstep_phase_gate.sv
module sixstep_phase_gate
    import sixstep_pkg::*;
#(
    parameter int DEAD_CYC = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  br_mode_e mode,
    input  logic     pwm,
    output logic     gate_hi,
    output logic     gate_lo
);
    localparam int TW = $clog2(DEAD_CYC + 1);

    typedef struct packed {
        logic [1:0]    req;   // {high, low}
        logic [TW-1:0] cnt;
        logic          hi;
        logic          lo;
    } gate_t;

    gate_t      g_d, g_q;
    logic [1:0] req;

    always_comb begin
        case (mode)
            BR_LOW:  req = 2'b01;
            BR_PWM:  req = {pwm, ~pwm};
            default: req = 2'b00;
        endcase

        g_d     = g_q;
        g_d.req = req;
        if (req != g_q.req)
            g_d.cnt = '0;
        else if (g_q.cnt != TW'(DEAD_CYC))
            g_d.cnt = g_q.cnt + TW'(1);
        g_d.hi = req[1] && (g_d.cnt == TW'(DEAD_CYC));
        g_d.lo = req[0] && (g_d.cnt == TW'(DEAD_CYC));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign gate_hi = g_q.hi;
    assign gate_lo = g_q.lo;
endmodule

// File: rtl/sixstep_commutator.sv
module sixstep_commutator
    import sixstep_pkg::*;
#(
    parameter int PWM_PERIOD = 1000,
    parameter int DEAD_CYC   = 3,
    parameter int DEB_CYC    = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [2:0]                      hall_in,
    input  logic [$clog2(PWM_PERIOD+1)-1:0] duty,
    output logic [2:0]                      gate_hi,
    output logic [2:0]                      gate_lo,
    output logic                            fault
);
    localparam int NPH = 3;

    typedef struct packed {
        br_mode_e ma;
        br_mode_e mb;
        br_mode_e mc;
        logic     fault;
    } cmt_t;

    cmt_t       cmt_d, cmt_q;
    logic [2:0] hall_clean;
    logic       hall_valid;
    logic       pwm;
    step_cmd_t  step;
    br_mode_e   ph_mode [NPH];

    sixstep_hall_filter #(.DEB_CYC(DEB_CYC)) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .hall_raw   (hall_in),
        .hall_clean (hall_clean),
        .hall_valid (hall_valid)
    );

    sixstep_pwm_gen #(.PWM_PERIOD(PWM_PERIOD)) u_pwm (
        .clk   (clk),
        .rst_n (rst_n),
        .duty  (duty),
        .pwm   (pwm)
    );

    always_comb begin
        step  = decode_hall(hall_clean);
        cmt_d = '{ma: BR_OFF, mb: BR_OFF, mc: BR_OFF, fault: 1'b0};
        if (hall_valid) begin
            cmt_d.ma    = step.a;
            cmt_d.mb    = step.b;
            cmt_d.mc    = step.c;
            cmt_d.fault = step.bad;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cmt_q <= '{ma: BR_OFF, mb: BR_OFF, mc: BR_OFF, fault: 1'b0};
        else        cmt_q <= cmt_d;
    end

    assign ph_mode[0] = cmt_q.ma;
    assign ph_mode[1] = cmt_q.mb;
    assign ph_mode[2] = cmt_q.mc;
    assign fault      = cmt_q.fault;

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        sixstep_phase_gate #(.DEAD_CYC(DEAD_CYC)) u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    (ph_mode[p]),
            .pwm     (pwm),
            .gate_hi (gate_hi[p]),
            .gate_lo (gate_lo[p])
        );
    end
endmodule

// File: rtl/sixstep_commutator_checker.sv
module sixstep_commutator_checker #(
    parameter int DEAD_CYC = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] gate_hi,
    input logic [2:0] gate_lo,
    input logic       fault
);
    localparam int IW = $clog2(DEAD_CYC + 1);

    // R10: no phase conducts through both switches
    assert_no_shoot_through_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == 3'b000);

    // R10: only the single modulated phase may close its high switch
    assert_single_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_hi));

    // R8: a fault that has lasted a cycle leaves every switch open
    assert_fault_all_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && $past(fault)) |-> ((gate_hi | gate_lo) == 3'b000));

    for (genvar p = 0; p < 3; p++) begin : g_dead
        logic [IW-1:0] idle_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                idle_q <= '0;
            else if (gate_hi[p] || gate_lo[p])
                idle_q <= '0;
            else if (idle_q != IW'(DEAD_CYC))
                idle_q <= idle_q + IW'(1);
        end

        // R7: a gate closes only after the full blanking gap
        assert_dead_gap_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_hi[p]) |-> (idle_q >= IW'(DEAD_CYC)));
        assert_dead_gap_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_lo[p]) |-> (idle_q >= IW'(DEAD_CYC)));
    end
endmodule

bind sixstep_commutator sixstep_commutator_checker #(.DEAD_CYC(DEAD_CYC)) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo),
    .fault   (fault)
);

// File: tb/sixstep_commutator_test.sv
module sixstep_commutator_test;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 64;
    localparam int DEAD       = 3;
    localparam int DEB        = 4;
    localparam int DW         = $clog2(P + 1);
    localparam int WIN        = 4 * P;
    localparam int SETTLE     = 2 * P + 24;
    localparam int M_OFF = 0, M_LOW = 1, M_PWM = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    hall_in = 3'b000;
    logic [DW-1:0] duty = '0;
    logic [2:0]    gate_hi, gate_lo;
    logic          fault;

    int checks = 0;
    int errors = 0;
    int pushed = 0;
    int done   = 0;
    int cycles = 0;

    typedef struct {
        int    m0, m1, m2;
        int    d;
        int    flt;
        string name;
    } item_t;

    item_t sb[$];

    sixstep_commutator #(.PWM_PERIOD(P), .DEAD_CYC(DEAD), .DEB_CYC(DEB)) uut (
        .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .duty(duty),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .fault(fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_hi(int m, int d);
        if (m != M_PWM || d == 0) return 0;
        if (d >= P) return WIN;
        return (d > DEAD) ? 4 * (d - DEAD) : 0;
    endfunction

    function automatic int exp_lo(int m, int d);
        if (m == M_OFF) return 0;
        if (m == M_LOW || d == 0) return WIN;
        if (d >= P) return 0;
        return (P - d > DEAD) ? 4 * (P - d - DEAD) : 0;
    endfunction

    function automatic string mode_req(int m, int d);
        if (m == M_OFF) return "R3";
        if (m == M_LOW) return "R4";
        if (d == 0 || d >= P) return "R6";
        return "R5/R7";
    endfunction

    // R2 step table from the requirement, phases A, B, C
    task automatic apply(input logic [2:0] code, input int d, input string name);
        item_t it;
        it.m0 = M_OFF; it.m1 = M_OFF; it.m2 = M_OFF; it.flt = 0;
        case (code)
            3'b000: begin it.m1 = M_LOW; it.m2 = M_PWM; end
            3'b100: begin it.m0 = M_PWM; it.m1 = M_LOW; end
            3'b110: begin it.m0 = M_PWM; it.m2 = M_LOW; end
            3'b111: begin it.m1 = M_PWM; it.m2 = M_LOW; end
            3'b011: begin it.m0 = M_LOW; it.m1 = M_PWM; end
            3'b001: begin it.m0 = M_LOW; it.m2 = M_PWM; end
            default: it.flt = 1;
        endcase
        it.d    = d;
        it.name = name;
        @(negedge clk);
        hall_in = code;
        duty    = DW'(d);
        sb.push_back(it);
        pushed++;
        wait (done == pushed);
    endtask

    // monitor: pops expectations and measures one steady window
    initial begin
        forever begin
            item_t it;
            int hc[3];
            int lc[3];
            int mm[3];
            int ov, fc;
            wait (sb.size() > 0);
            it = sb.pop_front();
            repeat (SETTLE) @(negedge clk);
            hc = '{0, 0, 0}; lc = '{0, 0, 0};
            ov = 0; fc = 0;
            repeat (WIN) begin
                @(negedge clk);
                for (int p = 0; p < 3; p++) begin
                    if (gate_hi[p]) hc[p]++;
                    if (gate_lo[p]) lc[p]++;
                end
                if ((gate_hi & gate_lo) != 0) ov++;
                if (fault) fc++;
            end
            mm = '{it.m0, it.m1, it.m2};
            for (int p = 0; p < 3; p++) begin
                chk({"R2 ", mode_req(mm[p], it.d)}, $sformatf("%s phase %0d high cycles", it.name, p),
                    hc[p], exp_hi(mm[p], it.d));
                chk({"R2 ", mode_req(mm[p], it.d)}, $sformatf("%s phase %0d low cycles", it.name, p),
                    lc[p], exp_lo(mm[p], it.d));
            end
            chk("R8", {it.name, " fault cycles"}, fc, it.flt * WIN);
            chk("R10", {it.name, " overlap cycles"}, ov, 0);
            done++;
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        int fseen;
        repeat (5) @(negedge clk);
        chk("R1", "gates in reset", int'({gate_hi, gate_lo}), 0);
        chk("R1", "fault in reset", int'(fault), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "gates before first filtered code", int'({gate_hi, gate_lo}), 0);

        // forward rotation, R2
        apply(3'b000, 20, "step1");
        apply(3'b100, 20, "step2");
        apply(3'b110, 20, "step3");
        apply(3'b111, 20, "step4");
        apply(3'b011, 20, "step5");
        apply(3'b001, 20, "step6");

        // R8 illegal codes, then recovery
        apply(3'b010, 20, "illegal010");
        apply(3'b101, 20, "illegal101");
        apply(3'b100, 20, "recover");

        // reverse rotation
        apply(3'b001, 40, "rev6");
        apply(3'b011, 40, "rev5");
        apply(3'b111, 40, "rev4");

        // duty corners on step1 (phase C modulated): R6, R5, R7
        apply(3'b000, 0,  "duty0");
        apply(3'b000, P,  "dutyfull");
        apply(3'b000, 2,  "dutyshort");
        apply(3'b000, 50, "duty50");

        // R9: a two-cycle illegal code must not pass the filter
        @(negedge clk);
        hall_in = 3'b010;
        repeat (2) @(negedge clk);
        hall_in = 3'b000;
        fseen = 0;
        repeat (30) begin
            @(negedge clk);
            if (fault) fseen++;
        end
        chk("R9", "fault after short glitch", fseen, 0);
        apply(3'b000, 50, "after_glitch_R9");

        finish_run();
    end
endmodule